// File: doc/BRIEF.md
# Exception Entry Stacking Sequencer

This block carries out the entry half of processor exception handling for traps and interrupts. A request names its cause: an interrupt with a supplied vector, a trap instruction with a 4-bit trap number, a bounds check, or an overflow check. It also carries the current status word, the stack pointer and the address information needed to form the return address. The sequencer works out the vector number and decides whether the exception is taken. If it is, the sequencer keeps an unmodified copy of the status word and produces an entry status word with supervisor mode on and tracing off.

It then writes a four-word frame onto the supervisor stack through a 16-bit memory port. Next it reads the 32-bit handler address from the vector table through the same port. It reports the handler address, the entry status word and the final stack pointer with a one-cycle done pulse. While a sequence is in flight the request ready output stays low.

Memory transfers use a simple request/acknowledge handshake. A transfer completes on a rising clock edge where both `mem_req` and `mem_ack` are high.

Top module: `exc_stacker`

## Requirements
- R1: After synchronous reset, `req_rdy` is 1, `done` is 0 and `mem_req` is 0.
- R2: The vector number is `req_int_vec` for cause 0 (interrupt), 32+`req_trap_num` for cause 1 (trap instruction), 6 for cause 2 (bounds check) and 7 for cause 3 (overflow check).
- R3: For an interrupt the stacked return address is `req_pc`; for the three trap causes it is `req_pc + req_ilen`.
- R4: A taken exception performs four writes, each at the stack pointer predecremented by 2. With entry pointer SP, the writes are: return address bits 15:0 at SP-2, return address bits 31:16 at SP-4, saved status at SP-6, and frame word at SP-8. `sp_out` is SP-8 at done.
- R5: The frame word has bits 15:12 equal to zero and bits 11:0 equal to the vector number times four.
- R6: The stacked status word is `sr_in` as presented with the request. At done, `sr_out` equals that value with bit 13 (supervisor) set and bit 15 (trace) cleared.
- R7: After the writes, the block reads the high half of the handler address at vector×4 and the low half at vector×4+2. At done, `pc_out` holds {high, low}.
- R8: A bounds-check or overflow-check request with `req_cond` low is not taken. It makes no memory transfer, and done comes with `taken`=0, `sr_out`=`sr_in`, `sp_out`=`sp_in` and `pc_out`=`req_pc+req_ilen`.
- R9: `req_rdy` is low from the cycle after acceptance until after the one-cycle `done` pulse. Requests presented while it is low have no effect.
- R10: While `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Exception request present |
| req_rdy | output | 1 | Sequencer idle, request accepted when valid |
| req_cause | input | 2 | 0 interrupt, 1 trap instruction, 2 bounds check, 3 overflow check |
| req_trap_num | input | 4 | Trap number taken from the instruction |
| req_cond | input | 1 | Error condition for bounds/overflow check |
| req_int_vec | input | 8 | Vector number supplied with an interrupt |
| req_pc | input | 32 | Current or pending instruction address |
| req_ilen | input | 4 | Byte length of the trapping instruction |
| sr_in | input | 16 | Status word before entry |
| sp_in | input | 32 | Supervisor stack pointer before entry |
| mem_req | output | 1 | Memory transfer requested |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Byte address of the 16-bit word |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Transfer completes this cycle |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Exception was taken |
| sr_out | output | 16 | Status word after entry |
| pc_out | output | 32 | Handler address or continue address |
| sp_out | output | 32 | Stack pointer after entry |

## Verification
The assertions take for granted that `mem_ack` is raised only while `mem_req` is high. They also assume that an acknowledged read returns its data in the same cycle. The stimulus respects both: the memory model drives `mem_ack` only after it sees `mem_req`, and it drives `mem_rdata` together with the acknowledge. The model also inserts zero or two wait cycles per transfer, so the hold behaviour is exercised under stalls. Requests are raised only after `req_rdy` is seen high, except for deliberate pokes while the sequencer is busy, which must be ignored.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int AW = 32;
    localparam int WW = 16;
    localparam int VW = 8;
    localparam int TNW = 4;
    localparam int ILW = 4;
    localparam int SUP_BIT = 13;
    localparam int TRC_BIT = 15;
    localparam int FRAME_WORDS = 4;
    localparam int IDX_W = $clog2(FRAME_WORDS);
    localparam logic [VW-1:0] VEC_CHK       = 8'd6;
    localparam logic [VW-1:0] VEC_TRAPV     = 8'd7;
    localparam logic [VW-1:0] VEC_TRAP_BASE = 8'd32;

    typedef enum logic [1:0] {
        K_IRQ   = 2'd0,
        K_TRAP  = 2'd1,
        K_CHK   = 2'd2,
        K_TRAPV = 2'd3
    } cause_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PUSH,
        S_RDHI,
        S_RDLO,
        S_DONE
    } st_e;

    typedef struct packed {
        logic [VW-1:0] vec;
        logic [AW-1:0] spc;
        logic [WW-1:0] sr_old;
        logic          taken;
    } ectx_t;

    function automatic logic [WW-1:0] fmt_word(input logic [VW-1:0] v);
        return {4'b0000, 2'b00, v, 2'b00};
    endfunction

    function automatic logic [WW-1:0] sr_enter(input logic [WW-1:0] s);
        logic [WW-1:0] r;
        r = s;
        r[SUP_BIT] = 1'b1;
        r[TRC_BIT] = 1'b0;
        return r;
    endfunction

    function automatic logic [AW-1:0] vec_addr(input logic [VW-1:0] v);
        return {{(AW-VW-2){1'b0}}, v, 2'b00};
    endfunction
endpackage

// File: rtl/exc_cause_dec.sv
module exc_cause_dec
    import exc_pkg::*;
(
    input  cause_e              cause,
    input  logic [TNW-1:0]      trap_num,
    input  logic                cond,
    input  logic [VW-1:0]       int_vec,
    input  logic [AW-1:0]       pc,
    input  logic [ILW-1:0]      ilen,
    output logic [VW-1:0]       vec,
    output logic                taken,
    output logic [AW-1:0]       spc
);
    logic [AW-1:0] pc_after;

    assign pc_after = pc + {{(AW-ILW){1'b0}}, ilen};

    always_comb begin
        vec   = int_vec;
        taken = 1'b1;
        spc   = pc_after;
        unique case (cause)
            K_IRQ: begin
                vec = int_vec;
                spc = pc;
            end
            K_TRAP: begin
                vec = VEC_TRAP_BASE + {{(VW-TNW){1'b0}}, trap_num};
            end
            K_CHK: begin
                vec   = VEC_CHK;
                taken = cond;
            end
            K_TRAPV: begin
                vec   = VEC_TRAPV;
                taken = cond;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/exc_frame_mux.sv
module exc_frame_mux
    import exc_pkg::*;
(
    input  ectx_t              ctx,
    input  logic [IDX_W-1:0]   idx,
    output logic [WW-1:0]      word
);
    logic [WW-1:0] words [FRAME_WORDS];

    assign words[0] = ctx.spc[WW-1:0];
    assign words[1] = ctx.spc[AW-1:WW];
    assign words[2] = ctx.sr_old;
    assign words[3] = fmt_word(ctx.vec);

    assign word = words[idx];
endmodule

// File: rtl/exc_seq.sv
module exc_seq
    import exc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_rdy,
    input  logic [VW-1:0]      dec_vec,
    input  logic               dec_taken,
    input  logic [AW-1:0]      dec_spc,
    input  logic [WW-1:0]      sr_in,
    input  logic [AW-1:0]      sp_in,
    output ectx_t              ctx,
    output logic [IDX_W-1:0]   idx,
    input  logic [WW-1:0]      frame_word,
    output logic               mem_req,
    output logic               mem_we,
    output logic [AW-1:0]      mem_addr,
    output logic [WW-1:0]      mem_wdata,
    input  logic               mem_ack,
    input  logic [WW-1:0]      mem_rdata,
    output logic               done,
    output logic [WW-1:0]      sr_out,
    output logic [AW-1:0]      pc_out,
    output logic [AW-1:0]      sp_out
);
    localparam logic [AW-1:0] WSTEP = AW'(WW/8);

    st_e           st;
    logic [AW-1:0] sp_q;
    logic [WW-1:0] pc_hi;
    logic [AW-1:0] pc_q;
    logic [WW-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= S_IDLE;
            ctx   <= '0;
            sp_q  <= '0;
            idx   <= '0;
            pc_hi <= '0;
            pc_q  <= '0;
            sr_q  <= '0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    if (req_valid) begin
                        ctx  <= '{vec: dec_vec, spc: dec_spc, sr_old: sr_in, taken: dec_taken};
                        sp_q <= sp_in;
                        idx  <= '0;
                        sr_q <= dec_taken ? sr_enter(sr_in) : sr_in;
                        if (dec_taken) begin
                            st <= S_PUSH;
                        end else begin
                            pc_q <= dec_spc;
                            st   <= S_DONE;
                        end
                    end
                end
                S_PUSH: begin
                    if (mem_ack) begin
                        sp_q <= sp_q - WSTEP;
                        idx  <= idx + 1'b1;
                        if (idx == IDX_W'(FRAME_WORDS-1)) st <= S_RDHI;
                    end
                end
                S_RDHI: begin
                    if (mem_ack) begin
                        pc_hi <= mem_rdata;
                        st    <= S_RDLO;
                    end
                end
                S_RDLO: begin
                    if (mem_ack) begin
                        pc_q <= {pc_hi, mem_rdata};
                        st   <= S_DONE;
                    end
                end
                S_DONE: st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        req_rdy   = (st == S_IDLE);
        done      = (st == S_DONE);
        mem_req   = (st == S_PUSH) || (st == S_RDHI) || (st == S_RDLO);
        mem_we    = (st == S_PUSH);
        mem_wdata = (st == S_PUSH) ? frame_word : '0;
        if (st == S_PUSH)
            mem_addr = sp_q - WSTEP;
        else if (st == S_RDLO)
            mem_addr = vec_addr(ctx.vec) + WSTEP;
        else
            mem_addr = vec_addr(ctx.vec);
    end

    assign sr_out = sr_q;
    assign pc_out = pc_q;
    assign sp_out = sp_q;
endmodule

// File: rtl/exc_stacker.sv
module exc_stacker
    import exc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_rdy,
    input  logic [1:0]         req_cause,
    input  logic [TNW-1:0]     req_trap_num,
    input  logic               req_cond,
    input  logic [VW-1:0]      req_int_vec,
    input  logic [AW-1:0]      req_pc,
    input  logic [ILW-1:0]     req_ilen,
    input  logic [WW-1:0]      sr_in,
    input  logic [AW-1:0]      sp_in,
    output logic               mem_req,
    output logic               mem_we,
    output logic [AW-1:0]      mem_addr,
    output logic [WW-1:0]      mem_wdata,
    input  logic               mem_ack,
    input  logic [WW-1:0]      mem_rdata,
    output logic               done,
    output logic               taken,
    output logic [WW-1:0]      sr_out,
    output logic [AW-1:0]      pc_out,
    output logic [AW-1:0]      sp_out
);
    logic [VW-1:0]    dec_vec;
    logic             dec_taken;
    logic [AW-1:0]    dec_spc;
    ectx_t            ctx;
    logic [IDX_W-1:0] idx;
    logic [WW-1:0]    frame_word;

    exc_cause_dec u_dec (
        .cause    (cause_e'(req_cause)),
        .trap_num (req_trap_num),
        .cond     (req_cond),
        .int_vec  (req_int_vec),
        .pc       (req_pc),
        .ilen     (req_ilen),
        .vec      (dec_vec),
        .taken    (dec_taken),
        .spc      (dec_spc)
    );

    exc_frame_mux u_frame (
        .ctx  (ctx),
        .idx  (idx),
        .word (frame_word)
    );

    exc_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_rdy    (req_rdy),
        .dec_vec    (dec_vec),
        .dec_taken  (dec_taken),
        .dec_spc    (dec_spc),
        .sr_in      (sr_in),
        .sp_in      (sp_in),
        .ctx        (ctx),
        .idx        (idx),
        .frame_word (frame_word),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .done       (done),
        .sr_out     (sr_out),
        .pc_out     (pc_out),
        .sp_out     (sp_out)
    );

    assign taken = ctx.taken;
endmodule

// File: rtl/exc_stacker_chk.sv
module exc_stacker_chk
    import exc_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           req_rdy,
    input logic           mem_req,
    input logic           mem_we,
    input logic [AW-1:0]  mem_addr,
    input logic [WW-1:0]  mem_wdata,
    input logic           mem_ack,
    input logic           done,
    input logic           taken,
    input logic [WW-1:0]  sr_out
);
    assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_req || done) |-> !req_rdy);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_hold_while_waiting_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    assert_word_aligned_R4: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !mem_addr[0]);

    assert_entry_mode_R6: assert property (@(posedge clk) disable iff (rst)
        (done && taken) |-> (sr_out[SUP_BIT] && !sr_out[TRC_BIT]));
endmodule

bind exc_stacker exc_stacker_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_rdy   (req_rdy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .done      (done),
    .taken     (taken),
    .sr_out    (sr_out)
);

// File: tb/exc_stacker_tb.sv
module exc_stacker_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_rdy;
    logic [1:0]  req_cause = 2'd0;
    logic [3:0]  req_trap_num = 4'd0;
    logic        req_cond = 1'b0;
    logic [7:0]  req_int_vec = 8'd0;
    logic [31:0] req_pc = 32'd0;
    logic [3:0]  req_ilen = 4'd0;
    logic [15:0] sr_in = 16'd0;
    logic [31:0] sp_in = 32'd0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = 16'd0;
    logic        done, taken;
    logic [15:0] sr_out;
    logic [31:0] pc_out, sp_out;

    typedef struct {
        logic        we;
        logic [31:0] addr;
        logic [15:0] data;
        string       tag;
    } xfer_t;

    typedef struct {
        logic        tk;
        logic [15:0] sr;
        logic [31:0] pc;
        logic [31:0] sp;
    } res_t;

    xfer_t exp_q[$];
    res_t  res_q[$];

    int n_tests = 0;
    int n_fail = 0;
    int wait_lim = 0;
    int wcnt = 0;
    int cycles = 0;
    logic [31:0] hold_addr = '0;
    logic        prev_done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_stacker u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_rdy(req_rdy),
        .req_cause(req_cause), .req_trap_num(req_trap_num), .req_cond(req_cond),
        .req_int_vec(req_int_vec), .req_pc(req_pc), .req_ilen(req_ilen),
        .sr_in(sr_in), .sp_in(sp_in), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .done(done), .taken(taken), .sr_out(sr_out),
        .pc_out(pc_out), .sp_out(sp_out)
    );

    function automatic logic [15:0] mdata(input logic [31:0] a);
        return a[15:0] ^ 16'h5A3C;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Memory model and monitor: acknowledge, compare against scoreboard
    always @(negedge clk) begin
        cycles++;
        mem_ack = 1'b0;
        if (!rst && mem_req) begin
            if (wcnt == 0) hold_addr = mem_addr;
            if (wcnt >= wait_lim) begin
                xfer_t e;
                if (wait_lim > 0)
                    check(mem_addr == hold_addr, "R10", "addr held", mem_addr, hold_addr);
                wcnt = 0;
                mem_ack = 1'b1;
                if (!mem_we) mem_rdata = mdata(mem_addr);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8", "unexpected transfer", mem_addr, 32'h0);
                end else begin
                    e = exp_q.pop_front();
                    check(mem_we == e.we, e.tag, "direction", {31'd0, mem_we}, {31'd0, e.we});
                    check(mem_addr == e.addr, e.tag, "address", mem_addr, e.addr);
                    if (e.we)
                        check(mem_wdata == e.data, e.tag, "wdata", {16'd0, mem_wdata}, {16'd0, e.data});
                end
            end else begin
                wcnt++;
            end
        end
        if (!rst && done) begin
            check(!prev_done, "R9", "done width", 32'd1, 32'd0);
            if (res_q.size() == 0) begin
                check(1'b0, "R9", "unexpected done", 32'd1, 32'd0);
            end else begin
                res_t r;
                r = res_q.pop_front();
                check(taken == r.tk, "R8", "taken", {31'd0, taken}, {31'd0, r.tk});
                check(sr_out == r.sr, "R6", "sr_out", {16'd0, sr_out}, {16'd0, r.sr});
                check(pc_out == r.pc, "R7", "pc_out", pc_out, r.pc);
                check(sp_out == r.sp, "R4", "sp_out", sp_out, r.sp);
            end
        end
        prev_done = done && !rst;
    end

    task automatic run_req(input logic [1:0] cause, input logic [3:0] tn, input logic cond,
                           input logic [7:0] ivec, input logic [31:0] pc, input logic [3:0] il,
                           input logic [15:0] sr, input logic [31:0] sp, input int wl,
                           input bit poke);
        logic [7:0]  v;
        logic        tk;
        logic [31:0] spc;
        logic [15:0] sr2;
        res_t        r;
        // R2 vector mapping, R3 return-address rule, R8 condition
        case (cause)
            2'd0: v = ivec;
            2'd1: v = 8'd32 + {4'd0, tn};
            2'd2: v = 8'd6;
            default: v = 8'd7;
        endcase
        tk  = (cause < 2) ? 1'b1 : cond;
        spc = (cause == 0) ? pc : pc + {28'd0, il};
        sr2 = sr;
        if (tk) begin
            sr2[13] = 1'b1;
            sr2[15] = 1'b0;
            exp_q.push_back('{1'b1, sp - 32'd2, spc[15:0], "R3"});
            exp_q.push_back('{1'b1, sp - 32'd4, spc[31:16], "R3"});
            exp_q.push_back('{1'b1, sp - 32'd6, sr, "R6"});
            exp_q.push_back('{1'b1, sp - 32'd8, {4'd0, 2'd0, v, 2'd0}, "R5"});
            exp_q.push_back('{1'b0, {22'd0, v, 2'd0}, 16'd0, "R2"});
            exp_q.push_back('{1'b0, {22'd0, v, 2'd0} + 32'd2, 16'd0, "R7"});
            r = '{1'b1, sr2, {mdata({22'd0, v, 2'd0}), mdata({22'd0, v, 2'd0} + 32'd2)}, sp - 32'd8};
        end else begin
            r = '{1'b0, sr, spc, sp};
        end
        res_q.push_back(r);
        wait_lim = wl;
        while (!req_rdy) @(negedge clk);
        req_cause = cause; req_trap_num = tn; req_cond = cond; req_int_vec = ivec;
        req_pc = pc; req_ilen = il; sr_in = sr; sp_in = sp;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            // R9: requests while busy are ignored
            req_cause = 2'd1; req_trap_num = 4'd9; req_pc = 32'h0BAD_0000;
            sp_in = 32'h0000_8000; req_valid = 1'b1;
            for (int k = 0; k < 3; k++) begin
                check(req_rdy == 1'b0, "R9", "rdy while busy", {31'd0, req_rdy}, 32'd0);
                @(negedge clk);
            end
            req_valid = 1'b0;
        end
        while (exp_q.size() != 0 || res_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(req_rdy == 1'b1, "R1", "rdy in reset", {31'd0, req_rdy}, 32'd1);
        check(done == 1'b0, "R1", "done in reset", {31'd0, done}, 32'd0);
        check(mem_req == 1'b0, "R1", "mem_req in reset", {31'd0, mem_req}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(req_rdy == 1'b1 && mem_req == 1'b0, "R1", "idle after reset", {31'd0, req_rdy}, 32'd1);
        // trap #0, trace set
        run_req(2'd1, 4'd0,  1'b0, 8'd0,  32'h0000_4000, 4'd2, 16'h8704, 32'h0000_1000, 0, 1'b0);
        // trap #15 with waits
        run_req(2'd1, 4'd15, 1'b0, 8'd0,  32'h1234_FFFE, 4'd2, 16'h0010, 32'h0000_2002, 2, 1'b1);
        // bounds check taken / not taken
        run_req(2'd2, 4'd0,  1'b1, 8'd0,  32'h0001_0100, 4'd4, 16'h801F, 32'h0000_3000, 0, 1'b0);
        run_req(2'd2, 4'd0,  1'b0, 8'd0,  32'h0001_0200, 4'd4, 16'h801F, 32'h0000_3000, 0, 1'b0);
        // overflow check taken / not taken
        run_req(2'd3, 4'd0,  1'b1, 8'd0,  32'h0002_0000, 4'd2, 16'h0700, 32'h0000_0800, 2, 1'b0);
        run_req(2'd3, 4'd0,  1'b0, 8'd0,  32'h0002_0010, 4'd2, 16'hA000, 32'h0000_0800, 2, 1'b0);
        // interrupts: return address is req_pc unchanged
        run_req(2'd0, 4'd0,  1'b0, 8'd25, 32'h00AB_CDE0, 4'd6, 16'h8300, 32'h0000_7FF0, 0, 1'b1);
        run_req(2'd0, 4'd0,  1'b0, 8'd255, 32'hFFFF_0002, 4'd2, 16'h2000, 32'h0001_0000, 2, 1'b0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        while (cycles < WATCHDOG) @(negedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule